// File: doc/BRIEF.md
# Exception Status and Cause Register Unit

This block holds the small set of control registers that a simple processor core consults when it takes an exception. It has five registers. The status register holds a per-line interrupt mask and a short stack of mode/enable bit pairs. The cause register holds the last exception code and a mirror of the pending interrupt lines. The trap PC register holds the return address, and the fault address register holds the address of the last failed memory reference.

When the pipeline reports an exception, the unit pushes the mode stack. This drops the core into kernel mode with interrupts disabled. It also records the instruction address and the reason code, and the faulting address when there is one. A return-from-exception request pops the stack. Software reads and writes the registers by index through a move-from port and a move-to port. A move-to issued in user mode changes nothing and instead raises a privilege exception. The unit also drives a registered interrupt request toward the core.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After synchronous reset, every register reads zero (kernel mode, interrupts disabled, mask clear), and `irq_req` and `rd_data` are 0.
- R2: Register indices are fixed: 8 is the fault address, 12 is status, 13 is cause and 14 is the trap PC. Any other index reads zero. `rd_data` shows the register value that held before the clock edge at which `rd_idx` was sampled, one cycle later.
- R3: Status layout: bits 15:8 are the interrupt mask, and bits 5:0 are three pairs (oldest in 5:4, middle in 3:2, current in 1:0). In each pair the upper bit is the mode (0 = kernel, 1 = user) and the lower bit is the enable (0 = disabled). Taking an exception sets bits 5:0 to {old bits 3:0, 2'b00} and leaves the mask unchanged.
- R4: Taking an exception stores `exc_pc` into the trap PC register and `exc_code` into cause bits 6:2.
- R5: The fault address register loads `exc_addr` only when an exception is taken with `exc_addr_valid` high. Otherwise it keeps its value.
- R6: A return request with no exception pending sets status bits 3:0 to the old bits 5:2 and keeps bits 5:4.
- R7: `irq_req` is registered. It equals status bit 0 AND the OR of (`irq_pending` & mask), both taken at the previous clock edge.
- R8: Exceptions take effect whatever the enable bit and the mask hold.
- R9: A kernel-mode write to status updates bits 15:8 and 5:0, and the other bits read 0. A write to the trap PC replaces all 32 bits. Writes to cause, to the fault address or to unmapped indices change nothing.
- R10: A write attempted while status bit 1 is 1 (user mode) changes no register as a write. Instead it acts as an exception with code 11, saving `wr_pc` as the trap PC.
- R11: Priority within one cycle: an exception first, then a user-mode write fault, then a return, then a kernel write. The losing requests are dropped.
- R12: Cause bits 15:8 hold `irq_pending` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception taken this cycle |
| exc_code | input | 5 | Reason code for the exception |
| exc_pc | input | 32 | Address of the affected instruction |
| exc_addr_valid | input | 1 | Exception is a memory reference error |
| exc_addr | input | 32 | Faulting data address |
| eret | input | 1 | Return from exception |
| irq_pending | input | 8 | Pending interrupt lines (5 hardware, 3 software) |
| rd_idx | input | 5 | Move-from register index |
| rd_data | output | 32 | Move-from data, registered |
| wr_en | input | 1 | Move-to request |
| wr_idx | input | 5 | Move-to register index |
| wr_data | input | 32 | Move-to data |
| wr_pc | input | 32 | Address of the move-to instruction |
| irq_req | output | 1 | Registered interrupt request |

## Verification
Every register update lands at the clock edge that samples the request. A read presents its result one edge after `rd_idx` is sampled, so a register change is seen two edges after its stimulus. The interrupt request follows status and pending one edge later. The cause pending field is visible through a read two edges after `irq_pending` changes. The bench drives every input at a falling edge and samples at the next falling edge, so each result is read exactly in the cycle it is due. An arithmetic model updated once per stimulus gives the expected values. The sweeps cover all 64 mode-stack patterns with a push, a pop and a write attempt each, and all 256 mask values against one-hot, empty and full pending patterns with the enable bit set and cleared.

// File: rtl/exc_regs_pkg.sv
package exc_regs_pkg;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned MASK_LSB = 8;
  localparam int unsigned CODE_LSB = 2;

  localparam logic [IDX_W-1:0] REG_FAULT_ADDR = 5'd8;
  localparam logic [IDX_W-1:0] REG_STATUS     = 5'd12;
  localparam logic [IDX_W-1:0] REG_CAUSE      = 5'd13;
  localparam logic [IDX_W-1:0] REG_TRAP_PC    = 5'd14;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_TRAP,
    ACT_PRIV,
    ACT_RETURN,
    ACT_WRITE
  } exc_act_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_regs_pkg::*;
(
  input  logic     exc_valid,
  input  logic     eret,
  input  logic     wr_en,
  input  logic     user_mode,
  output exc_act_e act
);
  always_comb begin
    if (exc_valid)              act = ACT_TRAP;
    else if (wr_en && user_mode) act = ACT_PRIV;
    else if (eret)              act = ACT_RETURN;
    else if (wr_en)             act = ACT_WRITE;
    else                        act = ACT_NONE;
  end

  always_comb begin
    assert (!(exc_valid && act != ACT_TRAP)) else $error("AST_TRAP_FIRST"); // R11
  end
endmodule

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
  import exc_regs_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PAIRS   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  exc_act_e           act,
  input  logic               sel_status,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic [2*PAIRS-1:0] pairs_o
);
  localparam int unsigned SW = 2 * PAIRS;

  logic [NUM_IRQ-1:0] mask_q;
  logic [SW-1:0]      pairs_q;
  logic [SW-1:0]      pushed;
  logic [SW-1:0]      popped;

  assign pushed = {pairs_q[SW-3:0], 2'b00};
  assign popped = {pairs_q[SW-1:SW-2], pairs_q[SW-1:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      pairs_q <= '0;
    end else begin
      unique case (act)
        ACT_TRAP, ACT_PRIV: pairs_q <= pushed;
        ACT_RETURN:         pairs_q <= popped;
        ACT_WRITE: begin
          if (sel_status) begin
            mask_q  <= wr_data[MASK_LSB +: NUM_IRQ];
            pairs_q <= wr_data[SW-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  assign mask_o  = mask_q;
  assign pairs_o = pairs_q;

  AST_PUSH_KERNEL: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_TRAP || act == ACT_PRIV) |=>
      (pairs_q[1:0] == 2'b00 && pairs_q[SW-1:2] == $past(pairs_q[SW-3:0]))); // R3
  AST_PUSH_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_TRAP) |=> $stable(mask_q)); // R3
  AST_POP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_RETURN) |=>
      (pairs_q[SW-3:0] == $past(pairs_q[SW-1:2]) &&
       pairs_q[SW-1:SW-2] == $past(pairs_q[SW-1:SW-2]))); // R6
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_regs_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned PRIV_CODE = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  exc_act_e           act,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic [DATA_W-1:0]  exc_pc,
  input  logic               exc_addr_valid,
  input  logic [DATA_W-1:0]  exc_addr,
  input  logic [DATA_W-1:0]  wr_pc,
  input  logic               sel_pc,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NUM_IRQ-1:0] irq_pending,
  output logic [CODE_W-1:0]  code_o,
  output logic [DATA_W-1:0]  pc_o,
  output logic [DATA_W-1:0]  fault_o,
  output logic [NUM_IRQ-1:0] pend_o
);
  localparam logic [CODE_W-1:0] PRIV_VAL = CODE_W'(PRIV_CODE);

  logic [CODE_W-1:0]  code_q;
  logic [DATA_W-1:0]  pc_q;
  logic [DATA_W-1:0]  fault_q;
  logic [NUM_IRQ-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      pc_q    <= '0;
      fault_q <= '0;
      pend_q  <= '0;
    end else begin
      pend_q <= irq_pending;
      unique case (act)
        ACT_TRAP: begin
          code_q <= exc_code;
          pc_q   <= exc_pc;
          if (exc_addr_valid) fault_q <= exc_addr;
        end
        ACT_PRIV: begin
          code_q <= PRIV_VAL;
          pc_q   <= wr_pc;
        end
        ACT_WRITE: begin
          if (sel_pc) pc_q <= wr_data;
        end
        default: ;
      endcase
    end
  end

  assign code_o  = code_q;
  assign pc_o    = pc_q;
  assign fault_o = fault_q;
  assign pend_o  = pend_q;

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(act == ACT_TRAP && exc_addr_valid) |=> $stable(fault_q)); // R5
  AST_PRIV_CODE: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_PRIV) |=> (code_q == PRIV_VAL)); // R10
  AST_TRAP_SAVE: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_TRAP) |=> (pc_q == $past(exc_pc) && code_q == $past(exc_code))); // R4
endmodule

// File: rtl/exc_irq_gen.sv
module exc_irq_gen #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] pending,
  output logic               irq_req_o
);
  logic [NUM_IRQ-1:0] hit;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign hit[i] = mask[i] & pending[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_req_o <= 1'b0;
    else     irq_req_o <= enable & (|hit);
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !irq_req_o); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((mask & pending) == '0) |=> !irq_req_o); // R7
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_regs_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned PAIRS     = 3,
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned PRIV_CODE = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_valid,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic [DATA_W-1:0]  exc_pc,
  input  logic               exc_addr_valid,
  input  logic [DATA_W-1:0]  exc_addr,
  input  logic               eret,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [DATA_W-1:0]  wr_pc,
  output logic               irq_req
);
  localparam int unsigned SW = 2 * PAIRS;

  exc_act_e           act;
  logic [NUM_IRQ-1:0] mask;
  logic [SW-1:0]      pairs;
  logic [CODE_W-1:0]  code;
  logic [DATA_W-1:0]  trap_pc;
  logic [DATA_W-1:0]  fault_addr;
  logic [NUM_IRQ-1:0] pend;
  logic [DATA_W-1:0]  status_word;
  logic [DATA_W-1:0]  cause_word;
  logic [DATA_W-1:0]  rd_q;
  logic               user_mode;

  assign user_mode = pairs[1];

  exc_arbiter i_arb (
    .exc_valid (exc_valid),
    .eret      (eret),
    .wr_en     (wr_en),
    .user_mode (user_mode),
    .act       (act)
  );

  exc_mode_stack #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ), .PAIRS(PAIRS)) i_stack (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .sel_status (wr_idx == REG_STATUS),
    .wr_data    (wr_data),
    .mask_o     (mask),
    .pairs_o    (pairs)
  );

  exc_capture #(.DATA_W(DATA_W), .CODE_W(CODE_W), .NUM_IRQ(NUM_IRQ),
                .PRIV_CODE(PRIV_CODE)) i_cap (
    .clk            (clk),
    .rst            (rst),
    .act            (act),
    .exc_code       (exc_code),
    .exc_pc         (exc_pc),
    .exc_addr_valid (exc_addr_valid),
    .exc_addr       (exc_addr),
    .wr_pc          (wr_pc),
    .sel_pc         (wr_idx == REG_TRAP_PC),
    .wr_data        (wr_data),
    .irq_pending    (irq_pending),
    .code_o         (code),
    .pc_o           (trap_pc),
    .fault_o        (fault_addr),
    .pend_o         (pend)
  );

  exc_irq_gen #(.NUM_IRQ(NUM_IRQ)) i_irq (
    .clk       (clk),
    .rst       (rst),
    .enable    (pairs[0]),
    .mask      (mask),
    .pending   (irq_pending),
    .irq_req_o (irq_req)
  );

  always_comb begin
    status_word = '0;
    status_word[MASK_LSB +: NUM_IRQ] = mask;
    status_word[SW-1:0] = pairs;
    cause_word = '0;
    cause_word[MASK_LSB +: NUM_IRQ] = pend;
    cause_word[CODE_LSB +: CODE_W] = code;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      unique case (rd_idx)
        REG_FAULT_ADDR: rd_q <= fault_addr;
        REG_STATUS:     rd_q <= status_word;
        REG_CAUSE:      rd_q <= cause_word;
        REG_TRAP_PC:    rd_q <= trap_pc;
        default:        rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_idx != REG_FAULT_ADDR && rd_idx != REG_STATUS &&
     rd_idx != REG_CAUSE && rd_idx != REG_TRAP_PC) |=> (rd_data == '0)); // R2
  AST_USER_WRITE_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && user_mode && !exc_valid) |=>
      (trap_pc == $past(wr_pc) && pairs[1:0] == 2'b00)); // R10
  AST_TRAP_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && wr_en) |=> (trap_pc == $past(exc_pc))); // R11
  AST_FAULT_NOT_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !exc_valid && wr_idx == REG_FAULT_ADDR) |=> $stable(fault_addr)); // R9
  AST_TRAP_ANY_ENABLE: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> (pairs[1:0] == 2'b00)); // R8
endmodule

// File: tb/test_exc_ctrl_regs.sv
module test_exc_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        exc_valid, exc_addr_valid, eret, wr_en;
  logic [4:0]  exc_code, rd_idx, wr_idx;
  logic [31:0] exc_pc, exc_addr, wr_data, wr_pc, rd_data;
  logic [7:0]  irq_pending;
  logic        irq_req;

  int nchk = 0;
  int nfail = 0;

  logic [7:0]  m_mask;
  logic [5:0]  m_pairs;
  logic [4:0]  m_code;
  logic [31:0] m_pc, m_bad;
  logic [7:0]  m_pend;

  always #10 clk = ~clk;

  exc_ctrl_regs i_exc_ctrl_regs (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_addr_valid(exc_addr_valid), .exc_addr(exc_addr),
    .eret(eret), .irq_pending(irq_pending), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_pc(wr_pc),
    .irq_req(irq_req)
  );

  task automatic tick();
    @(negedge clk);
    m_pend = irq_pending;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] st_word();
    return {16'h0, m_mask, 2'b00, m_pairs};
  endfunction

  function automatic logic [31:0] cause_word();
    return {16'h0, m_pend, 1'b0, m_code, 2'b00};
  endfunction

  task automatic read_chk(input logic [4:0] idx, input logic [31:0] exp, input string tag);
    rd_idx = idx;
    tick();
    check(tag, rd_data, exp);
  endtask

  task automatic apply_exc(input logic [4:0] code, input logic [31:0] pc,
                           input logic av, input logic [31:0] addr);
    exc_valid = 1'b1; exc_code = code; exc_pc = pc;
    exc_addr_valid = av; exc_addr = addr;
    tick();
    exc_valid = 1'b0; exc_addr_valid = 1'b0;
    m_pairs = {m_pairs[3:0], 2'b00};
    m_code = code; m_pc = pc;
    if (av) m_bad = addr;
  endtask

  task automatic do_write(input logic [4:0] idx, input logic [31:0] data, input logic [31:0] pc);
    wr_en = 1'b1; wr_idx = idx; wr_data = data; wr_pc = pc;
    tick();
    wr_en = 1'b0;
    if (m_pairs[1]) begin
      m_pairs = {m_pairs[3:0], 2'b00};
      m_code = 5'd11; m_pc = pc;
    end else if (idx == 5'd12) begin
      m_mask = data[15:8]; m_pairs = data[5:0];
    end else if (idx == 5'd14) begin
      m_pc = data;
    end
  endtask

  task automatic do_eret();
    eret = 1'b1;
    tick();
    eret = 1'b0;
    m_pairs = {m_pairs[5:4], m_pairs[5:2]};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; exc_valid = 1'b0; exc_addr_valid = 1'b0; eret = 1'b0; wr_en = 1'b0;
    exc_code = '0; exc_pc = '0; exc_addr = '0; wr_idx = '0; wr_data = '0; wr_pc = '0;
    rd_idx = 5'd12; irq_pending = '0;
    m_mask = '0; m_pairs = '0; m_code = '0; m_pc = '0; m_bad = '0; m_pend = '0;
    repeat (3) tick();
    rst = 1'b0;

    // R1 reset state
    check("R1 irq_req", {31'b0, irq_req}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    read_chk(5'd12, 32'h0, "R1 status");
    read_chk(5'd13, 32'h0, "R1 cause");
    read_chk(5'd14, 32'h0, "R1 trap pc");
    read_chk(5'd8,  32'h0, "R1 fault addr");

    // R9 read-only registers and unmapped writes in kernel mode
    do_write(5'd13, 32'hFFFF_FFFF, 32'h40);
    do_write(5'd8,  32'hDEAD_BEEF, 32'h44);
    do_write(5'd3,  32'h1234_5678, 32'h48);
    read_chk(5'd13, cause_word(), "R9 cause write ignored");
    read_chk(5'd8,  m_bad, "R9 fault write ignored");
    do_write(5'd14, 32'hCAFE_F00D, 32'h4C);
    read_chk(5'd14, 32'hCAFE_F00D, "R9 trap pc write");
    do_write(5'd12, 32'hFFFF_FFFF, 32'h50);
    read_chk(5'd12, 32'h0000_FF3F, "R9 status writable bits");

    // R2 unmapped indices read zero
    read_chk(5'd0,  32'h0, "R2 idx0");
    read_chk(5'd9,  32'h0, "R2 idx9");
    read_chk(5'd15, 32'h0, "R2 idx15");
    read_chk(5'd31, 32'h0, "R2 idx31");

    // Sweep of all mode-stack patterns: R3 R4 R5 R6 R8 R9 R10
    for (int v = 0; v < 64; v++) begin
      apply_exc(5'(v + 1), 32'h1000 + 32'(v) * 4, v[0], 32'hA000_0000 + 32'(v));
      do_write(5'd12, {16'h0, 8'(v * 37), 2'b11, 6'(v)}, 32'h2000 + 32'(v));
      read_chk(5'd12, st_word(), "R9 status write");
      apply_exc(5'(31 - v[4:0]), 32'h3000 + 32'(v) * 8, 1'b0, 32'hFFFF_FFFF);
      read_chk(5'd12, st_word(), "R3 R8 push");
      read_chk(5'd14, m_pc, "R4 trap pc");
      read_chk(5'd13, cause_word(), "R4 cause code");
      read_chk(5'd8,  m_bad, "R5 fault addr");
      do_eret();
      read_chk(5'd12, st_word(), "R6 pop");
      do_eret();
      read_chk(5'd12, st_word(), "R6 second pop");
      do_write(5'd14, 32'h5555_0000 + 32'(v), 32'h6000 + 32'(v));
      read_chk(5'd12, st_word(), "R10 status after write attempt");
      read_chk(5'd13, cause_word(), "R10 cause after write attempt");
      read_chk(5'd14, m_pc, "R10 trap pc after write attempt");
    end

    // R11 exception beats a write in the same cycle
    apply_exc(5'd2, 32'h700, 1'b0, 32'h0);
    wr_en = 1'b1; wr_idx = 5'd12; wr_data = 32'h0000_FF3F; wr_pc = 32'h710;
    exc_valid = 1'b1; exc_code = 5'd4; exc_pc = 32'h720;
    tick();
    wr_en = 1'b0; exc_valid = 1'b0;
    m_pairs = {m_pairs[3:0], 2'b00}; m_code = 5'd4; m_pc = 32'h720;
    read_chk(5'd12, st_word(), "R11 trap over write status");
    read_chk(5'd14, m_pc, "R11 trap over write pc");
    // R11 return beats a kernel write
    do_write(5'd12, 32'h0000_0010, 32'h730);
    wr_en = 1'b1; wr_idx = 5'd14; wr_data = 32'hBAD0_0000; eret = 1'b1;
    tick();
    wr_en = 1'b0; eret = 1'b0;
    m_pairs = {m_pairs[5:4], m_pairs[5:2]};
    read_chk(5'd14, m_pc, "R11 return over write pc");
    read_chk(5'd12, st_word(), "R11 return over write status");

    // R5 address captured only with the memory-error flag
    apply_exc(5'd4, 32'h800, 1'b1, 32'h1357_9BDF);
    read_chk(5'd8, 32'h1357_9BDF, "R5 capture");
    apply_exc(5'd8, 32'h804, 1'b0, 32'h0000_1111);
    read_chk(5'd8, 32'h1357_9BDF, "R5 hold");

    // Interrupt sweep: R7 R12, enable set then cleared
    for (int en = 1; en >= 0; en--) begin
      for (int m = 0; m < 256; m++) begin
        do_write(5'd12, {16'h0, 8'(m), 7'b0, 1'(en)}, 32'h900);
        for (int p = 0; p < 10; p++) begin
          irq_pending = (p < 8) ? 8'(1 << p) : ((p == 8) ? 8'h00 : 8'hFF);
          tick();
          check("R7 irq_req", {31'b0, irq_req},
                {31'b0, m_pairs[0] & (|(m_pend & m_mask))});
          if (p == 3 || p == 9) read_chk(5'd13, cause_word(), "R12 pending mirror");
        end
      end
    end
    irq_pending = '0;
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule